// File: doc/BRIEF.md
# Split-Bank Byte Write Strobe Generator

This block sits between a 16-bit processor bus and a memory built from two 8-bit halves. The even half holds even byte addresses on data bits 7..0. The odd half holds odd byte addresses on data bits 15..8. On every bus cycle the block looks at several inputs:

- the active-low high-byte enable;
- address bit 0;
- the memory/IO qualifier, which is high for memory;
- an externally decoded active-low chip select;
- the active-low bus write and read strobes.

From these it produces a separate active-low write strobe for each half, so a byte write to an even address, a byte write to an odd address and a full word write each change only the bytes they target. It also produces active-low read enables for both halves.

All outputs are registered, which keeps the strobes free of glitches. Each output reflects the inputs sampled at the previous rising clock edge. A cycle in which both bus strobes are low is treated as a bus fault and issues nothing.

Top module: `split_bank_strobe`

## Requirements
- R1: While reset is held low, and in the cycle after, every write strobe and read enable output is high (inactive).
- R2: A memory write with bhe_n=0 and a0=0 (word) drives both wr_lo_n and wr_hi_n low.
- R3: A memory write with bhe_n=0 and a0=1 (odd byte) drives only wr_hi_n low. wr_lo_n stays high.
- R4: A memory write with bhe_n=1 and a0=0 (even byte) drives only wr_lo_n low. wr_hi_n stays high.
- R5: A memory write with bhe_n=1 and a0=1 drives neither write strobe low.
- R6: A write strobe goes low only when wr_n=0, cs_n=0 and m_io=1 all hold together. If any of them is missing, both write strobes stay high.
- R7: A read (rd_n=0, wr_n=1, cs_n=0, m_io=1) drives both rd_lo_n and rd_hi_n low, whatever bhe_n and a0 are. Otherwise both stay high.
- R8: When wr_n and rd_n are both low, all four outputs stay high.
- R9: Every output reflects the inputs sampled at the preceding rising edge of clk, with exactly one cycle of latency.
- R10: In a byte-array memory driven by the write strobes, a byte in a half whose write strobe stays high is never modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select from the upper address decoder, active low |
| m_io | input | 1 | 1 = memory cycle, 0 = IO cycle |
| bhe_n | input | 1 | High-byte enable, active low |
| a0 | input | 1 | Address bit 0 |
| wr_n | input | 1 | Bus write strobe, active low |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_lo_n | output | 1 | Write strobe for the even half (bits 7..0), active low |
| wr_hi_n | output | 1 | Write strobe for the odd half (bits 15..8), active low |
| rd_lo_n | output | 1 | Read enable for the even half, active low |
| rd_hi_n | output | 1 | Read enable for the odd half, active low |

## Verification
Every strobe and read enable is due exactly one clock after the bus inputs are applied.

The driver applies inputs on a falling edge and queues the expected output pattern along with the target word and data. The monitor compares the outputs 1 ns after the next rising edge, so each queued item is checked in the single cycle in which its result is valid.

At the same point the monitor feeds the actual strobes into a two-half byte-array model. It then compares the addressed word against a shadow copy that the driver updated from the requirements alone. A final sweep of every word confirms that no byte outside the selected half was touched.

// File: rtl/split_bank_pkg.sv
// Package: shared constants and types for the split-bank strobe generator.
// Assumes exactly two 8-bit halves; bit index 0 is the even half and 1 the odd.
package split_bank_pkg;
    localparam int NBANK  = 2;
    localparam int LO_IDX = 0;
    localparam int HI_IDX = 1;

    typedef logic [NBANK-1:0] bank_vec_t;

    typedef struct packed {
        logic wr_ok;   // qualified write cycle
        logic rd_ok;   // qualified read cycle
    } cyc_qual_t;
endpackage

// File: rtl/bank_select.sv
// Module: bank_select
// Turns the high-byte enable and address bit 0 into one select bit per half.
// The even half needs a0 low; the odd half needs bhe_n low. Purely combinational.
module bank_select
    import split_bank_pkg::*;
(
    input  logic      bhe_n,
    input  logic      a0,
    output bank_vec_t sel
);
    // Compute the per-half select from the two byte-lane inputs.
    always_comb begin
        sel         = '0;
        sel[LO_IDX] = ~a0;
        sel[HI_IDX] = ~bhe_n;
    end
endmodule

// File: rtl/cycle_qualify.sv
// Module: cycle_qualify
// Decides whether the current bus cycle is a valid memory write or read
// aimed at this memory. Assumes the chip select is already decoded from the
// upper address bits. If both bus strobes are low, the cycle is treated as
// faulty and neither qualifier is raised.
module cycle_qualify
    import split_bank_pkg::*;
(
    input  logic      cs_n,
    input  logic      m_io,
    input  logic      wr_n,
    input  logic      rd_n,
    output cyc_qual_t qual
);
    logic mem_hit;
    logic clash;

    // Qualify the cycle on select, memory space and a single active strobe.
    always_comb begin
        mem_hit    = ~cs_n & m_io;
        clash      = ~wr_n & ~rd_n;
        qual.wr_ok = mem_hit & ~wr_n & ~clash;
        qual.rd_ok = mem_hit & ~rd_n & ~clash;
    end
endmodule

// File: rtl/bank_strobe_reg.sv
// Module: bank_strobe_reg
// Holds one registered, active-low write strobe and read enable per half.
// Writes are gated by each half's select; reads open every half. Reset is
// synchronous and active low, and it drives every output inactive.
module bank_strobe_reg
    import split_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bank_vec_t sel,
    input  cyc_qual_t qual,
    output bank_vec_t wr_q_n,
    output bank_vec_t rd_q_n
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Register this half's strobes so that they change only on the clock edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_q_n[b] <= 1'b1;
                rd_q_n[b] <= 1'b1;
            end else begin
                wr_q_n[b] <= ~(qual.wr_ok & sel[b]);
                rd_q_n[b] <= ~qual.rd_ok;
            end
        end
    end
endmodule

// File: rtl/split_bank_strobe.sv
// Module: split_bank_strobe (top)
// Generates per-half write strobes and read enables for a 16-bit bus whose
// memory is split into an even (bits 7..0) and an odd (bits 15..8) byte half.
// Assumes synchronous bus inputs. Outputs carry one cycle of latency.
module split_bank_strobe
    import split_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic m_io,
    input  logic bhe_n,
    input  logic a0,
    input  logic wr_n,
    input  logic rd_n,
    output logic wr_lo_n,
    output logic wr_hi_n,
    output logic rd_lo_n,
    output logic rd_hi_n
);
    bank_vec_t sel;
    cyc_qual_t qual;
    bank_vec_t wr_q_n;
    bank_vec_t rd_q_n;

    bank_select u_sel (
        .bhe_n (bhe_n),
        .a0    (a0),
        .sel   (sel)
    );

    cycle_qualify u_qual (
        .cs_n (cs_n),
        .m_io (m_io),
        .wr_n (wr_n),
        .rd_n (rd_n),
        .qual (qual)
    );

    bank_strobe_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .qual   (qual),
        .wr_q_n (wr_q_n),
        .rd_q_n (rd_q_n)
    );

    // Map the per-half vectors onto the named output ports.
    always_comb begin
        wr_lo_n = wr_q_n[LO_IDX];
        wr_hi_n = wr_q_n[HI_IDX];
        rd_lo_n = rd_q_n[LO_IDX];
        rd_hi_n = rd_q_n[HI_IDX];
    end
endmodule

// File: rtl/split_bank_strobe_chk.sv
// Module: split_bank_strobe_chk
// Checks the registered strobes against the bus inputs of the previous cycle.
// It is attached to the top module by the bind statement below.
module split_bank_strobe_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic m_io,
    input logic bhe_n,
    input logic a0,
    input logic wr_n,
    input logic rd_n,
    input logic wr_lo_n,
    input logic wr_hi_n,
    input logic rd_lo_n,
    input logic rd_hi_n
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wr_lo_n && wr_hi_n && rd_lo_n && rd_hi_n));

    p_word_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cs_n) && $past(m_io) && !$past(wr_n) && $past(rd_n)
         && !$past(bhe_n) && !$past(a0)) |-> (!wr_lo_n && !wr_hi_n));

    p_hi_needs_bhe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi_n |-> !$past(bhe_n));

    p_lo_needs_a0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo_n |-> !$past(a0));

    p_wr_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo_n || !wr_hi_n) |-> (!$past(cs_n) && $past(m_io) && !$past(wr_n)));

    p_rd_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo_n == rd_hi_n);

    p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !((!wr_lo_n || !wr_hi_n) && (!rd_lo_n || !rd_hi_n)));
endmodule

bind split_bank_strobe split_bank_strobe_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .m_io    (m_io),
    .bhe_n   (bhe_n),
    .a0      (a0),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .wr_lo_n (wr_lo_n),
    .wr_hi_n (wr_hi_n),
    .rd_lo_n (rd_lo_n),
    .rd_hi_n (rd_hi_n)
);

// File: tb/split_bank_strobe_tb.sv
`timescale 1ns/100ps
module split_bank_strobe_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, m_io = 1'b0, bhe_n = 1'b1, a0 = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic wr_lo_n, wr_hi_n, rd_lo_n, rd_hi_n;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [3:0]  exp;   // {wr_lo_n, wr_hi_n, rd_lo_n, rd_hi_n}
        int          idx;
        logic [15:0] data;
        string       tag;
    } item_t;
    item_t q[$];

    logic [7:0] lo_mem [16];
    logic [7:0] hi_mem [16];
    logic [7:0] exp_lo [16];
    logic [7:0] exp_hi [16];

    always #2.5 clk = ~clk;

    split_bank_strobe u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .m_io(m_io), .bhe_n(bhe_n),
        .a0(a0), .wr_n(wr_n), .rd_n(rd_n),
        .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .rd_lo_n(rd_lo_n), .rd_hi_n(rd_hi_n)
    );

    // Driver: apply one bus cycle on a falling edge and queue its expected result.
    task automatic drive(input logic c, input logic m, input logic b, input logic a,
                         input logic w, input logic r, input int idx,
                         input logic [15:0] d, input string tag);
        item_t it;
        logic wr, rd;
        @(negedge clk);
        cs_n = c; m_io = m; bhe_n = b; a0 = a; wr_n = w; rd_n = r;
        wr = !c && m && !w && r;
        rd = !c && m && !r && w;
        it.exp  = {!(wr && !a), !(wr && !b), !rd, !rd};
        it.idx  = idx;
        it.data = d;
        it.tag  = tag;
        if (wr && !a) exp_lo[idx] = d[7:0];
        if (wr && !b) exp_hi[idx] = d[15:8];
        q.push_back(it);
    endtask

    // Monitor: one cycle after each drive, compare the strobes and update the memory model.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            logic [3:0] act;
            it = q.pop_front();
            act = {wr_lo_n, wr_hi_n, rd_lo_n, rd_hi_n};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s strobes: actual=%b expected=%b", it.tag, act, it.exp);
            end
            if (!wr_lo_n) lo_mem[it.idx] = it.data[7:0];
            if (!wr_hi_n) hi_mem[it.idx] = it.data[15:8];
            total++;
            if ({hi_mem[it.idx], lo_mem[it.idx]} !== {exp_hi[it.idx], exp_lo[it.idx]}) begin
                bad++;
                $display("FAIL R10 %s word %0d: actual=%h expected=%h", it.tag, it.idx,
                         {hi_mem[it.idx], lo_mem[it.idx]}, {exp_hi[it.idx], exp_lo[it.idx]});
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            lo_mem[i] = 8'h00; hi_mem[i] = 8'h00; exp_lo[i] = 8'h00; exp_hi[i] = 8'h00;
        end
        // R1: reset held while a word write is presented on the bus.
        @(negedge clk);
        cs_n = 0; m_io = 1; bhe_n = 0; a0 = 0; wr_n = 0; rd_n = 1;
        repeat (3) @(posedge clk);
        #1;
        total++;
        if ({wr_lo_n, wr_hi_n, rd_lo_n, rd_hi_n} !== 4'b1111) begin
            bad++;
            $display("FAIL R1 reset: actual=%b expected=1111", {wr_lo_n, wr_hi_n, rd_lo_n, rd_hi_n});
        end
        @(negedge clk);
        cs_n = 1; wr_n = 1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        total++;
        if ({wr_lo_n, wr_hi_n, rd_lo_n, rd_hi_n} !== 4'b1111) begin
            bad++;
            $display("FAIL R1 after release: actual=%b expected=1111", {wr_lo_n, wr_hi_n, rd_lo_n, rd_hi_n});
        end

        // Args: cs_n, m_io, bhe_n, a0, wr_n, rd_n, word, data
        drive(0, 1, 0, 0, 0, 1, 0, 16'hA1B2, "R2 word write");
        drive(0, 1, 0, 1, 0, 1, 1, 16'hC3D4, "R3 odd byte write");
        drive(0, 1, 1, 0, 0, 1, 2, 16'hE5F6, "R4 even byte write");
        drive(0, 1, 1, 1, 0, 1, 3, 16'h1122, "R5 no-lane write");
        drive(1, 1, 0, 0, 0, 1, 4, 16'h3344, "R6 cs inactive");
        drive(0, 0, 0, 0, 0, 1, 5, 16'h5566, "R6 IO cycle");
        drive(0, 1, 0, 0, 1, 1, 6, 16'h7788, "R6 no strobe");
        drive(0, 1, 1, 1, 1, 0, 0, 16'h0000, "R7 read no lanes");
        drive(0, 1, 0, 1, 1, 0, 1, 16'h0000, "R7 read odd");
        drive(1, 1, 0, 0, 1, 0, 2, 16'h0000, "R7 read deselected");
        drive(0, 0, 0, 0, 1, 0, 2, 16'h0000, "R7 read IO");
        drive(0, 1, 0, 0, 0, 0, 7, 16'h99AA, "R8 clash");
        // R9: back-to-back cycles that each take effect the following cycle.
        drive(0, 1, 1, 0, 0, 1, 0, 16'hFF5A, "R9 even then odd");
        drive(0, 1, 0, 1, 0, 1, 0, 16'hA5FF, "R9 odd after even");
        drive(0, 1, 0, 0, 0, 1, 8, 16'h1357, "R10 word");
        drive(0, 1, 1, 0, 0, 1, 8, 16'h00EE, "R10 even over word");
        drive(0, 1, 0, 1, 0, 1, 8, 16'hDD00, "R10 odd over word");
        drive(0, 1, 1, 1, 1, 1, 0, 16'h0000, "R9 idle");
        @(negedge clk);
        cs_n = 1; wr_n = 1; rd_n = 1;
        repeat (3) @(posedge clk);
        #2;
        // R10: sweep every word for bytes touched outside their selected half.
        for (int i = 0; i < 16; i++) begin
            total++;
            if ({hi_mem[i], lo_mem[i]} !== {exp_hi[i], exp_lo[i]}) begin
                bad++;
                $display("FAIL R10 sweep word %0d: actual=%h expected=%h", i,
                         {hi_mem[i], lo_mem[i]}, {exp_hi[i], exp_lo[i]});
            end
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule